// File: doc/BRIEF.md
# 128-bit Lane Permute Unit

This block rearranges the words, halfwords or bytes of two 128-bit source operands into one 128-bit result, the way a wide-register shuffle instruction in an execution pipe would. Each operand is seen as four 32-bit words, w0 the least significant and w3 the most significant. A 3-bit select picks one of seven fixed shuffles: even-word pack, lower interleave, upper word interleave, halfword broadcast, lower-doubleword copy, upper-doubleword copy and a three-word rotate.

Alongside the data the unit takes the register indices of both sources and of the destination. A source whose index is zero contributes all zeros whatever value sits on its data port, and a destination index of zero leaves the write enable low. The permute itself is pure wiring and multiplexing. It is followed by a single output register stage, so a request presented in one cycle produces its result, write enable and destination index on the next rising edge. The lane width of the lower interleave is a parameter (8, 16 or 32 bits) that selects the structure at elaboration.

Top module: `lperm_unit`

## Requirements
- R1: Select code 0 (even-word pack) yields, from w3 down to w0, {rs.w2, rs.w0, rt.w2, rt.w0}.
- R2: Select code 1 (lower interleave) takes the lower 64 bits of each source and alternates lanes of ILV_LANE bits over the full result, rt lane k at even lane 2k and rs lane k at odd lane 2k+1; with the default 32-bit lanes this is w0=rt.w0, w1=rs.w0, w2=rt.w1, w3=rs.w1.
- R3: Select code 2 (upper word interleave) yields w0=rt.w2, w1=rs.w2, w2=rt.w3, w3=rs.w3.
- R4: Select code 3 (halfword broadcast) copies halfword 0 of each 64-bit half of rt into all four halfwords of that same half; rs is not used.
- R5: Select code 4 (lower-doubleword copy) yields result bits 127:64 = rs bits 63:0 and bits 63:0 = rt bits 63:0.
- R6: Select code 5 (upper-doubleword copy) yields result bits 63:0 = rs bits 127:64 and bits 127:64 = rt bits 127:64.
- R7: Select code 6 (three-word rotate) yields w0=rt.w1, w1=rt.w2, w2=rt.w0 and w3=rt.w3.
- R8: A source index of zero makes that source read as all zeros, regardless of its data port.
- R9: A destination index of zero keeps the write enable low while the result value is still produced.
- R10: Select code 7 is reserved: it produces an all-zero result with the write enable low.
- R11: Result, write enable and destination index appear on the first rising edge after the request; the write enable is high only for a valid request; reset clears result, write enable and destination index to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| op_sel | input | 3 | Shuffle select (codes 0 to 6, 7 reserved) |
| rs_idx | input | 5 | Register index of the first source |
| rt_idx | input | 5 | Register index of the second source |
| rd_idx | input | 5 | Register index of the destination |
| rs_val | input | 128 | First source data |
| rt_val | input | 128 | Second source data |
| res_val | output | 128 | Permuted result, registered |
| res_we | output | 1 | Write enable for the result, registered |
| res_rd | output | 5 | Destination index travelling with the result |

## Verification
Every result, write enable and destination index is due exactly one rising edge after the falling edge at which the request is driven. The driver tags each expected item with the cycle number of that edge, and the monitor pops an item only when the edge counter has reached its tag, comparing at the following falling edge so the registered outputs are stable. Register-zero sources, a zero destination, an invalid request and the reserved code are each sent as their own requests, so their effect is seen on the very cycle they are due rather than inferred later.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

    typedef enum logic [2:0] {
        SH_PACK_EVEN = 3'd0,
        SH_ILV_LO    = 3'd1,
        SH_ILV_HI_W  = 3'd2,
        SH_BCAST_H   = 3'd3,
        SH_COPY_LO_D = 3'd4,
        SH_COPY_HI_D = 3'd5,
        SH_ROT3_W    = 3'd6,
        SH_RESERVED  = 3'd7
    } shuf_op_t;

endpackage

// File: rtl/lperm_src_gate.sv
module lperm_src_gate #(
    parameter int DATA_W = 128,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] val
);

    // Register zero is hard-wired to zero.
    always_comb begin
        if (idx == '0) val = '0;
        else           val = raw;
    end

endmodule

// File: rtl/lperm_shuffle.sv
module lperm_shuffle
    import lperm_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int ILV_LANE = 32
) (
    input  shuf_op_t          op,
    input  logic [DATA_W-1:0] src_s,
    input  logic [DATA_W-1:0] src_t,
    output logic [DATA_W-1:0] result,
    output logic              op_ok
);

    localparam int WORD_W   = DATA_W / 4;
    localparam int HALF_W   = DATA_W / 2;
    localparam int HWORD_W  = HALF_W / 4;
    localparam int ILV_N    = HALF_W / ILV_LANE;

    logic [WORD_W-1:0] s_w [4];
    logic [WORD_W-1:0] t_w [4];

    for (genvar i = 0; i < 4; i++) begin : g_words
        assign s_w[i] = src_s[i*WORD_W +: WORD_W];
        assign t_w[i] = src_t[i*WORD_W +: WORD_W];
    end

    // Lower interleave at the configured lane width.
    logic [DATA_W-1:0] ilv_lo;
    for (genvar k = 0; k < ILV_N; k++) begin : g_ilv
        assign ilv_lo[(2*k)*ILV_LANE   +: ILV_LANE] = src_t[k*ILV_LANE +: ILV_LANE];
        assign ilv_lo[(2*k+1)*ILV_LANE +: ILV_LANE] = src_s[k*ILV_LANE +: ILV_LANE];
    end

    // Halfword broadcast within each 64-bit half.
    logic [DATA_W-1:0] bcast;
    for (genvar h = 0; h < 2; h++) begin : g_bc_half
        for (genvar q = 0; q < 4; q++) begin : g_bc_lane
            assign bcast[h*HALF_W + q*HWORD_W +: HWORD_W] = src_t[h*HALF_W +: HWORD_W];
        end
    end

    always_comb begin
        result = '0;
        op_ok  = 1'b1;
        unique case (op)
            SH_PACK_EVEN: result = {s_w[2], s_w[0], t_w[2], t_w[0]};
            SH_ILV_LO:    result = ilv_lo;
            SH_ILV_HI_W:  result = {s_w[3], t_w[3], s_w[2], t_w[2]};
            SH_BCAST_H:   result = bcast;
            SH_COPY_LO_D: result = {src_s[HALF_W-1:0], src_t[HALF_W-1:0]};
            SH_COPY_HI_D: result = {src_t[DATA_W-1:HALF_W], src_s[DATA_W-1:HALF_W]};
            SH_ROT3_W:    result = {t_w[3], t_w[0], t_w[2], t_w[1]};
            SH_RESERVED: begin
                result = '0;
                op_ok  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lperm_unit.sv
module lperm_unit
    import lperm_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int IDX_W    = 5,
    parameter int ILV_LANE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        op_sel,
    input  logic [IDX_W-1:0]  rs_idx,
    input  logic [IDX_W-1:0]  rt_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic [DATA_W-1:0] res_val,
    output logic              res_we,
    output logic [IDX_W-1:0]  res_rd
);

    localparam int HALF_W = DATA_W / 2;
    localparam int WORD_W = DATA_W / 4;

    logic [DATA_W-1:0] s_gated;
    logic [DATA_W-1:0] t_gated;
    logic [DATA_W-1:0] perm;
    logic              op_ok;
    logic              we_next;

    lperm_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_s (
        .idx (rs_idx),
        .raw (rs_val),
        .val (s_gated)
    );

    lperm_src_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gate_t (
        .idx (rt_idx),
        .raw (rt_val),
        .val (t_gated)
    );

    lperm_shuffle #(.DATA_W(DATA_W), .ILV_LANE(ILV_LANE)) u_shuf (
        .op     (shuf_op_t'(op_sel)),
        .src_s  (s_gated),
        .src_t  (t_gated),
        .result (perm),
        .op_ok  (op_ok)
    );

    assign we_next = req_valid && op_ok && (rd_idx != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_val <= '0;
            res_we  <= 1'b0;
            res_rd  <= '0;
        end else begin
            res_val <= perm;
            res_we  <= we_next;
            res_rd  <= rd_idx;
        end
    end

    // R9
    rd_zero_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |=> !res_we);

    // R10
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |=> (res_val == '0 && !res_we));

    // R7
    rot3_top_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd6 && rt_idx != '0) |=>
            (res_val[DATA_W-1 -: WORD_W] == $past(rt_val[DATA_W-1 -: WORD_W])));

    // R8
    zero_src_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3 && rt_idx == '0) |=> (res_val == '0));

    // R5
    copy_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4 && rs_idx != '0 && rt_idx != '0) |=>
            (res_val == {$past(rs_val[HALF_W-1:0]), $past(rt_val[HALF_W-1:0])}));

    // R11
    idle_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_we);

endmodule

// File: tb/lperm_unit_bench.sv
module lperm_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   op_sel = '0;
    logic [4:0]   rs_idx = '0;
    logic [4:0]   rt_idx = '0;
    logic [4:0]   rd_idx = '0;
    logic [127:0] rs_val = '0;
    logic [127:0] rt_val = '0;
    logic [127:0] res_val;
    logic         res_we;
    logic [4:0]   res_rd;

    int tests_run = 0;
    int tests_failed = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int           due;
        logic [127:0] val;
        logic         we;
        logic [4:0]   rd;
        string        req;
    } exp_t;

    exp_t sb_q[$];

    lperm_unit u_lperm_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_sel(op_sel),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx),
        .rs_val(rs_val), .rt_val(rt_val),
        .res_val(res_val), .res_we(res_we), .res_rd(res_rd)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] wd(logic [127:0] v, int i);
        return v[i*32 +: 32];
    endfunction

    function automatic logic [127:0] model(logic [2:0] op, logic [127:0] a, logic [127:0] b);
        logic [15:0] h0, h1;
        case (op)
            3'd0: return {wd(a,2), wd(a,0), wd(b,2), wd(b,0)};
            3'd1: return {wd(a,1), wd(b,1), wd(a,0), wd(b,0)};
            3'd2: return {wd(a,3), wd(b,3), wd(a,2), wd(b,2)};
            3'd3: begin
                h0 = b[15:0];
                h1 = b[79:64];
                return {h1, h1, h1, h1, h0, h0, h0, h0};
            end
            3'd4: return {a[63:0], b[63:0]};
            3'd5: return {b[127:64], a[127:64]};
            3'd6: return {wd(b,3), wd(b,0), wd(b,2), wd(b,1)};
            default: return '0;
        endcase
    endfunction

    task automatic send(input string req, input logic v, input logic [2:0] op,
                        input logic [4:0] s_i, input logic [4:0] t_i, input logic [4:0] d_i,
                        input logic [127:0] a, input logic [127:0] b);
        exp_t e;
        logic [127:0] ea, eb;
        @(negedge clk);
        req_valid = v; op_sel = op; rs_idx = s_i; rt_idx = t_i; rd_idx = d_i;
        rs_val = a; rt_val = b;
        ea = (s_i == 0) ? '0 : a;
        eb = (t_i == 0) ? '0 : b;
        e.due = cyc + 1;
        e.val = model(op, ea, eb);
        e.we  = v && (op != 3'd7) && (d_i != 0);
        e.rd  = d_i;
        e.req = req;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            tests_run++;
            if (res_val !== e.val || res_we !== e.we || res_rd !== e.rd) begin
                tests_failed++;
                $display("FAIL %s: got val=%h we=%b rd=%0d exp val=%h we=%b rd=%0d",
                         e.req, res_val, res_we, res_rd, e.val, e.we, e.rd);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    localparam logic [127:0] A = 128'h33332222_11110000_0fedcba9_87654321;
    localparam logic [127:0] B = 128'hdddd_cccc_bbbb_aaaa_9999_8888_7777_6666;
    localparam logic [127:0] C = 128'hffff0000_a5a5a5a5_12345678_deadbeef;

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        tests_run++;
        if (res_val !== '0 || res_we !== 1'b0 || res_rd !== '0) begin
            tests_failed++;
            $display("FAIL R11 reset: got val=%h we=%b rd=%0d exp zeros", res_val, res_we, res_rd);
        end
        rst_n = 1'b1;

        send("R1 pack even",        1, 3'd0, 5'd1, 5'd2, 5'd3, A, B);
        send("R1 pack even swap",   1, 3'd0, 5'd2, 5'd1, 5'd4, B, C);
        send("R2 lower interleave", 1, 3'd1, 5'd1, 5'd2, 5'd5, A, B);
        send("R3 upper interleave", 1, 3'd2, 5'd1, 5'd2, 5'd6, A, C);
        send("R4 halfword bcast",   1, 3'd3, 5'd1, 5'd2, 5'd7, A, B);
        send("R4 bcast other src",  1, 3'd3, 5'd9, 5'd2, 5'd7, C, C);
        send("R5 copy lower dw",    1, 3'd4, 5'd1, 5'd2, 5'd8, A, B);
        send("R6 copy upper dw",    1, 3'd5, 5'd1, 5'd2, 5'd9, A, B);
        send("R7 rotate three",     1, 3'd6, 5'd1, 5'd2, 5'd10, A, C);
        send("R8 rs zero index",    1, 3'd4, 5'd0, 5'd2, 5'd11, A, B);
        send("R8 rt zero index",    1, 3'd6, 5'd1, 5'd0, 5'd12, A, B);
        send("R8 both zero",        1, 3'd0, 5'd0, 5'd0, 5'd13, A, B);
        send("R9 rd zero",          1, 3'd2, 5'd1, 5'd2, 5'd0, A, B);
        send("R10 reserved code",   1, 3'd7, 5'd1, 5'd2, 5'd14, A, B);
        send("R11 invalid request", 0, 3'd1, 5'd1, 5'd2, 5'd15, C, A);
        send("R11 back to back",    1, 3'd5, 5'd3, 5'd4, 5'd31, C, A);
        send("R11 flush",           0, 3'd0, 5'd0, 5'd0, 5'd0, '0, '0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule